// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is a byte-wide serial shifter for SPI-style links on three lines: a data input, a data output and a serial clock. Software loads a byte into the data register, and that byte leaves on the data output MSB first. The bit read on each sampling edge enters at the LSB, so when a transfer ends the data register holds the byte received. A 4-bit counter counts every serial clock edge, both rising and falling. Sixteen edges are eight clock pulses, and on the sixteenth the counter sets an overflow flag that marks the byte as complete. That flag can raise an interrupt or wake request.

The serial clock has two possible sources. One is an external pin, which is brought into the system clock domain through a two-flop synchronizer. The other is a toggle strobe in the control register: each write of the strobe inverts the block's own clock output, which is how the block acts as master. An edge-select bit picks which clock edge samples the input and which edge shifts the register. Pin direction control lies outside the block.

Register map on `addr`: 0 is data, 1 is status, 2 is control. Reads are combinational on `rdata`.

Top module: `tw_shift_unit`

## Requirements
- R1: After reset the data register, the status register, the control bits, `sck_out` and `irq` all read 0.
- R2: `so` always presents bit 7 of the data register. A write to address 0 loads the data register, and reading address 0 returns it.
- R3: With edge-select (control bit 2) at 0, the block latches `si` on a rising serial clock edge and shifts the register left on a falling edge, taking the latched bit in at the LSB.
- R4: With edge-select at 1, the block latches `si` on a falling edge and shifts on a rising edge.
- R5: The counter (status bits 3:0) advances on both serial clock edges. On the edge that would take it past 15 it wraps to 0 and sets the overflow flag (status bit 7). After 8 full pulses the data register holds the received byte, MSB first.
- R6: Writing control with bit 7 set inverts `sck_out`. Bit 7 always reads 0. With clock source (control bit 1) at 1, each toggle is one serial edge, and it takes effect in the cycle after the write.
- R7: A write to status with bit 7 set clears the overflow flag. Every status write loads the counter from bits 3:0, and the write wins over a clock edge in the same cycle.
- R8: `irq` is high exactly while the overflow flag and the interrupt enable (control bit 3) are both set.
- R9: With clock source at 0, edges on `sck_in` pass through two synchronizer flops plus an edge detector. A pin change is acted on within 4 system clock cycles.
- R10: With enable (control bit 0) at 0, serial clock edges leave the counter, the flag and the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| sck_in | input | 1 | External serial clock pin |
| sck_out | output | 1 | Serial clock driven by toggle strobes |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| irq | output | 1 | Overflow interrupt or wake request |

## Verification
The assertions take for granted that software does not change the clock source, enable or edge-select bits in the middle of a byte. They also assume that `sck_in` holds each level for at least two system clock cycles, and that `si` is stable around the sampling edge. The stimulus keeps to all of these. Before it loads data and clears the status, it sets the configuration and brings `sck_out` to the idle level the chosen mode needs. It changes `si` only on the falling system clock edge, ahead of the strobe that samples it, and it holds each external clock level for several cycles.

// File: rtl/tw_shift_unit.sv
module tw_shift_unit #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          sck_in,
  output logic          sck_out,
  input  logic          si,
  output logic          so,
  output logic          irq
);

  localparam logic [1:0] A_DAT = 2'd0;
  localparam logic [1:0] A_STA = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

  logic [3:0]    ctl_q;
  logic          sck_q, tog_q;
  logic          s1_q, s2_q, s3_q;
  logic          lat_q;
  logic [DW-1:0] dr_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;

  wire ena      = ctl_q[0];
  wire src_str  = ctl_q[1];
  wire edge_sel = ctl_q[2];
  wire ie       = ctl_q[3];

  wire wr_dat = wr_en && addr == A_DAT;
  wire wr_sta = wr_en && addr == A_STA;
  wire wr_ctl = wr_en && addr == A_CTL;

  wire ext_rise = s2_q & ~s3_q;
  wire ext_fall = ~s2_q & s3_q;
  wire str_rise = tog_q & sck_q;
  wire str_fall = tog_q & ~sck_q;

  wire rise  = ena & (src_str ? str_rise : ext_rise);
  wire fall  = ena & (src_str ? str_fall : ext_fall);
  wire samp  = edge_sel ? fall : rise;
  wire shft  = edge_sel ? rise : fall;
  wire any_e = rise | fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= sck_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sck_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      tog_q <= wr_ctl & wdata[7];
      if (wr_ctl) begin
        ctl_q <= wdata[3:0];
        if (wdata[7]) sck_q <= ~sck_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= 1'b0;
      dr_q  <= '0;
    end else begin
      if (samp) lat_q <= si;
      if (wr_dat)    dr_q <= wdata;
      else if (shft) dr_q <= {dr_q[DW-2:0], lat_q};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (wr_sta) begin
      cnt_q <= wdata[CW-1:0];
      if (wdata[7]) ovf_q <= 1'b0;
    end else if (any_e) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_TOP) ovf_q <= 1'b1;
    end
  end

  assign sck_out = sck_q;
  assign so      = dr_q[DW-1];
  assign irq     = ovf_q & ie;

  always_comb begin
    unique case (addr)
      A_DAT:   rdata = dr_q;
      A_STA:   rdata = {ovf_q, {(DW-1-CW){1'b0}}, cnt_q};
      A_CTL:   rdata = {4'b0000, ctl_q};
      default: rdata = '0;
    endcase
  end

  p_wrap_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_e && cnt_q == CNT_TOP && !wr_sta) |=> (ovf_q && cnt_q == '0));

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_e && !wr_sta) |=> cnt_q == $past(cnt_q) + 1'b1);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sta && wdata[7]) |=> !ovf_q);

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sta |=> cnt_q == $past(wdata[CW-1:0]));

  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata[7]) |=> sck_out != $past(sck_out));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ena && !wr_sta && !wr_dat) |=> ($stable(cnt_q) && $stable(dr_q)));

  p_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shft && !wr_dat) |=> dr_q[DW-1:1] == $past(dr_q[DW-2:0]));

endmodule

// File: tb/tw_shift_unit_tb_top.sv
module tw_shift_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck_in = 1'b0, sck_out, si = 1'b0, so, irq;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_shift_unit dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_in(sck_in), .sck_out(sck_out),
    .si(si), .so(so), .irq(irq));

  // {tx[7:0], rx[7:0], mode}
  localparam logic [16:0] VEC [4] = '{
    {8'hA5, 8'h3C, 1'b0},
    {8'h00, 8'hFF, 1'b0},
    {8'hC3, 8'h96, 1'b1},
    {8'h7E, 8'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic tog(input logic [7:0] c);
    wr(2'd2, c | 8'h80);
    @(negedge clk);
  endtask

  logic [7:0] r;
  logic [7:0] ctl;
  logic [7:0] rx;
  logic [7:0] tx;
  logic md;

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 data", r, 8'h00);
    rd(2'd1, r); chk("R1 status", r, 8'h00);
    rd(2'd2, r); chk("R1 control", r, 8'h00);
    chk("R1 sck_out/irq", {6'b0, sck_out, irq}, 8'h00);

    wr(2'd0, 8'h81);
    rd(2'd0, r); chk("R2 data readback", r, 8'h81);
    chk("R2 so msb", {7'b0, so}, 8'h01);

    foreach (VEC[v]) begin
      tx = VEC[v][16:9]; rx = VEC[v][8:1]; md = VEC[v][0];
      ctl = {4'b0000, 1'b1, md, 1'b1, 1'b1};
      wr(2'd2, ctl);
      if (sck_out != md) tog(ctl);
      wr(2'd0, tx);
      wr(2'd1, 8'h80);
      for (int b = 0; b < 8; b++) begin
        chk(md ? "R4 so bit" : "R3 so bit", {7'b0, so}, {7'b0, tx[7-b]});
        si = rx[7-b];
        tog(ctl);
        tog(ctl);
      end
      rd(2'd0, r); chk(md ? "R4 rx byte" : "R3 rx byte", r, rx);
      rd(2'd1, r); chk("R5 flag set cnt wrapped", r, 8'h80);
      chk("R8 irq", {7'b0, irq}, 8'h01);
    end

    wr(2'd1, 8'h80);
    rd(2'd1, r); chk("R7 clear", r, 8'h00);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    wr(2'd2, 8'h03);
    if (sck_out) tog(8'h03);
    wr(2'd1, 8'h0D);
    rd(2'd1, r); chk("R7 load", r, 8'h0D);
    tog(8'h03); tog(8'h03);
    rd(2'd1, r); chk("R6 strobe counts", r, 8'h0F);
    chk("R6 sck_out level", {7'b0, sck_out}, 8'h00);
    rd(2'd2, r); chk("R6 strobe reads 0", r, 8'h03);
    tog(8'h03);
    rd(2'd1, r); chk("R5 wrap from 15", r, 8'h80);
    chk("R8 irq masked", {7'b0, irq}, 8'h00);

    wr(2'd1, 8'h80);
    wr(2'd0, 8'h5A);
    wr(2'd2, 8'h02);
    tog(8'h02); tog(8'h02);
    rd(2'd1, r); chk("R10 count frozen", r, 8'h00);
    rd(2'd0, r); chk("R10 data frozen", r, 8'h5A);

    wr(2'd2, 8'h01);
    si = 1'b1;
    @(negedge clk); sck_in = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, r); chk("R9 ext rise counted", r, 8'h01);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    rd(2'd1, r); chk("R9 ext fall counted", r, 8'h02);
    rd(2'd0, r); chk("R9 ext shift", r, 8'hB5);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule